// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Unit

This block watches a port of input pins and turns chosen transitions on them into one interrupt request. Each pin has its own polarity bit, pending flag and mask bit. The pins are resynchronised to the local clock, and the synchronised level is compared with its value one cycle earlier. When the transition that the polarity bit selects appears, the pin's pending flag is set. A flag stays set until software clears it.

Software reaches the three per-pin registers through a small register bus. Writes take effect on the clock edge. Reads are combinational from the address. Software may also write a flag to 1 to raise an interrupt without any pin activity. The request output is high while any pin has both its flag and its mask bit set.

Top module: `port_irq_unit`

## Requirements
- R1: After reset the polarity, flag and mask registers read 0x00 and irq_o is low.
- R2: With a polarity bit of 0, a 0-to-1 transition on that pin sets its flag. With the default two synchroniser stages, the flag reads 1 after the third rising clock edge following the pin change, and still reads 0 after the second.
- R3: With a polarity bit of 1, a 1-to-0 transition sets the pin's flag, and a 0-to-1 transition leaves it clear.
- R4: A pin held at a steady level, high or low, never sets its flag, however long it is held.
- R5: A flag bit of 1 means pending. A flag stays set until a write to the flag register puts 0 in that bit. A write of 1 sets the bit, which raises a software interrupt. A write replaces all flag bits at once.
- R6: When a selected transition and a software write of 0 to the same flag bit fall in the same cycle, the flag ends up set.
- R7: irq_o is high exactly when at least one pin has both its flag bit and its mask bit at 1. A mask bit of 0 blocks that pin's flag from the request, and the flag itself is unchanged.
- R8: A write to the polarity register, whatever the pin levels are, does not set any flag.
- R9: The register map is: address 0 = polarity, 1 = flags, 2 = mask, and bit n of each register belongs to pin n. Address 3 reads 0x00 and ignores writes.
- R10: Pins act independently, so one pattern can set some flags and leave others clear, each pin following its own polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata_i | input | NUM_PINS | Write data |
| bus_rdata_o | output | NUM_PINS | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: eight pins and two synchroniser stages, which gives a transition-to-flag latency of three edges. With eight pins, a single vector can give every pin a different polarity and mask bit, so mixed patterns test the pins' independence and the per-pin masking in one step. With the short synchroniser, the bench can place a selected transition exactly in the cycle of a software clear, and it can check the exact cycle in which a flag first shows.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_POL  = 2'd0,
    REG_FLAG = 2'd1,
    REG_MASK = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  // pol 0: rising, pol 1: falling
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign hit_o[i] = pol_i[i] ? fall : rise;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] flag_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [WIDTH-1:0] flag_q;

  // hardware set overrides a software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (wr_i ? wdata_i : flag_q) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic                  bus_we_i,
  input  logic [NUM_PINS-1:0]   bus_wdata_i,
  output logic [NUM_PINS-1:0]   bus_rdata_o,
  output logic                  irq_o
);
  timeunit 1ns;
  timeprecision 100ps;

  reg_addr_e        addr;
  logic [NUM_PINS-1:0] pol_q, mask_q, flag_q, lvl, hit;
  logic             wr_pol, wr_flag, wr_mask;

  assign addr    = reg_addr_e'(bus_addr_i);
  assign wr_pol  = bus_we_i && (addr == REG_POL);
  assign wr_flag = bus_we_i && (addr == REG_FLAG);
  assign wr_mask = bus_we_i && (addr == REG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= bus_wdata_i;
      if (wr_mask) mask_q <= bus_wdata_i;
    end
  end

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  edge_detect #(.WIDTH(NUM_PINS)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .pol_i (pol_q),
    .hit_o (hit)
  );

  flag_reg #(.WIDTH(NUM_PINS)) i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .wr_i   (wr_flag),
    .wdata_i(bus_wdata_i),
    .flag_o (flag_q)
  );

  always_comb begin
    unique case (addr)
      REG_POL:  bus_rdata_o = pol_q;
      REG_FLAG: bus_rdata_o = flag_q;
      REG_MASK: bus_rdata_o = mask_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/port_irq_chk.sv
module port_irq_chk
  import port_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_we_i,
  input logic [REG_ADDR_W-1:0] bus_addr_i,
  input logic [NUM_PINS-1:0]   bus_wdata_i,
  input logic [NUM_PINS-1:0]   flag_q,
  input logic [NUM_PINS-1:0]   mask_q,
  input logic [NUM_PINS-1:0]   pol_q,
  input logic [NUM_PINS-1:0]   lvl,
  input logic [NUM_PINS-1:0]   hit,
  input logic                  irq_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic                wr_flag;
  logic [NUM_PINS-1:0] wr_bits;

  assign wr_flag = bus_we_i && (bus_addr_i == REG_FLAG);
  assign wr_bits = wr_flag ? bus_wdata_i : '0;

  AST_RISE_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ~pol_q & ~lvl) == '0); // R2

  AST_FALL_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & pol_q & lvl) == '0); // R3

  AST_LEVEL_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ~(lvl ^ $past(lvl))) == '0); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R5

  AST_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_q & $past(hit)) == $past(hit)); // R6

  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|(flag_q & mask_q))); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(hit) & ~$past(wr_bits)) == '0); // R8
endmodule

bind port_irq_unit port_irq_chk #(.NUM_PINS(NUM_PINS)) i_port_irq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .pol_q      (pol_q),
  .lvl        (lvl),
  .hit        (hit),
  .irq_o      (irq_o)
);

// File: tb/test_port_irq_unit.sv
module test_port_irq_unit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NP = 8;
  localparam logic [1:0] A_POL = 2'd0, A_FLAG = 2'd1, A_MASK = 2'd2, A_RSVD = 2'd3;

  typedef struct packed {
    logic [7:0] pol;
    logic [7:0] mask;
    logic [7:0] p0;
    logic [7:0] p1;
    logic [7:0] flag;
    logic       irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, 4'd2},  // R2 all rising
    '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b1, 4'd3},  // R3 all falling
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd3},  // R3 wrong edge
    '{8'h0F, 8'h00, 8'h0F, 8'hF0, 8'hFF, 1'b0, 4'd7},  // R7 masked
    '{8'hAA, 8'h01, 8'h55, 8'hAA, 8'h00, 1'b0, 4'd10}, // R10 all wrong edge
    '{8'h00, 8'h04, 8'h00, 8'h05, 8'h05, 1'b1, 4'd10}, // R10 partial, R7 one unmasked
    '{8'h00, 8'hFF, 8'h3C, 8'h3C, 8'h00, 1'b0, 4'd4}   // R4 unchanged levels
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic [1:0]    addr;
  logic          we;
  logic [NP-1:0] wdata;
  logic [NP-1:0] rdata;
  logic          irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  port_irq_unit #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_port_irq_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .bus_addr_i (addr),
    .bus_we_i   (we),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    #0.5;
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) tick();
    chk_reg("R1 pol in reset", A_POL, 8'h00);
    rst_n = 1'b1;
    tick();
    chk_reg("R1 pol", A_POL, 8'h00);
    chk_reg("R1 flag", A_FLAG, 8'h00);
    chk_reg("R1 mask", A_MASK, 8'h00);
    chk_irq("R1 irq", 1'b0);

    for (int v = 0; v < NV; v++) begin
      wr(A_POL, VECS[v].pol);
      wr(A_MASK, VECS[v].mask);
      pin = VECS[v].p0;
      repeat (4) tick();
      wr(A_FLAG, 8'h00);
      pin = VECS[v].p1;
      repeat (3) tick();
      chk_reg($sformatf("R%0d vector %0d flag", VECS[v].req, v), A_FLAG, VECS[v].flag);
      chk_irq($sformatf("R%0d vector %0d irq", VECS[v].req, v), VECS[v].irq);
    end

    // R2 latency
    wr(A_POL, 8'h00);
    wr(A_MASK, 8'h01);
    pin = 8'h00;
    repeat (4) tick();
    wr(A_FLAG, 8'h00);
    pin = 8'h01;
    tick(); tick();
    chk_reg("R2 flag not yet set", A_FLAG, 8'h00);
    tick();
    chk_reg("R2 flag set on third edge", A_FLAG, 8'h01);
    chk_irq("R2 irq", 1'b1);

    // R4 long steady high
    wr(A_FLAG, 8'h00);
    repeat (10) tick();
    chk_reg("R4 steady high", A_FLAG, 8'h00);
    chk_irq("R4 irq", 1'b0);

    // R5 software set and clear
    wr(A_FLAG, 8'h81);
    chk_reg("R5 sw set", A_FLAG, 8'h81);
    chk_irq("R5 irq from sw set", 1'b1);
    wr(A_FLAG, 8'h80);
    chk_reg("R5 sw clear bit0", A_FLAG, 8'h80);
    chk_irq("R7 bit7 masked", 1'b0);
    repeat (5) tick();
    chk_reg("R5 flag sticky", A_FLAG, 8'h80);
    wr(A_FLAG, 8'h00);
    chk_reg("R5 sw clear all", A_FLAG, 8'h00);

    // R6 hardware set collides with software clear
    pin = 8'h00;
    repeat (4) tick();
    wr(A_FLAG, 8'h02);
    pin = 8'h01;
    tick(); tick();
    wr(A_FLAG, 8'h00);
    chk_reg("R6 hw set wins", A_FLAG, 8'h01);

    // R8 polarity writes with pins high and low
    wr(A_FLAG, 8'h00);
    pin = 8'hF0;
    repeat (4) tick();
    wr(A_FLAG, 8'h00);
    wr(A_POL, 8'hFF);
    wr(A_POL, 8'h0F);
    wr(A_POL, 8'h00);
    repeat (4) tick();
    chk_reg("R8 polarity change", A_FLAG, 8'h00);

    // R9 reserved address
    wr(A_MASK, 8'h5A);
    wr(A_RSVD, 8'hFF);
    chk_reg("R9 reserved reads zero", A_RSVD, 8'h00);
    chk_reg("R9 mask untouched", A_MASK, 8'h5A);
    chk_reg("R9 pol untouched", A_POL, 8'h00);
    chk_reg("R9 flag untouched", A_FLAG, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule